// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This peripheral sits on the processor's byte-wide register bus and gathers interrupt requests. Up to seven hardware request lines and one software-interrupt strobe from the core each set a bit in a pending-flag byte. A mask byte enables each flag. When an enabled flag is pending and no earlier interrupt is still being serviced, the controller issues a one-cycle redirect pulse. The pulse carries the programmed handler address and the index of the flag it selected. In the same cycle the controller captures the core's next program counter into a read-only return-address register.

The controller raises a wake output while any enabled flag is pending, which releases a halted core. Software clears flags by writing the pending byte. The core reports the end of service on a done strobe, and only after that strobe can the controller take another interrupt. When several enabled flags are pending, the lowest bit index wins.

Register offsets on the bus: 0 and 1 are the return address (low byte, then high byte, read-only), 2 is the mask, 3 is the pending byte, and 4 and 5 are the handler address (low byte, then high byte). Offsets 6 and 7 read as zero.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all registers read 0, `redirect_valid` is 0 and `wake` is 0.
- R2: Reads are combinational while `bus_sel`=1 and `bus_we`=0. Offset 0 returns the return-address low byte and offset 1 its high byte. Offset 2 returns the mask, offset 3 the pending byte, offset 4 the handler low byte and offset 5 the handler high byte. Offsets 6 and 7 return 0.
- R3: The mask (offset 2) and the handler (offsets 4 and 5) take the written byte at the clock edge of the write. Writes to offsets 0 and 1 leave the return address unchanged.
- R4: A 0-to-1 transition on `src_line[n]` sets pending bit n at the next edge. A line held high does not set the bit again after software has cleared it.
- R5: `swi_req` high at an edge sets pending bit 7.
- R6: A write to offset 3 replaces the pending byte. A flag set arriving at the same edge wins over the written 0 for that bit.
- R7: In a cycle where pending AND mask is nonzero and no service is open, the controller takes the interrupt. At the next edge `redirect_valid` is 1 for exactly one cycle, `redirect_addr` equals the handler, and the return address equals `next_pc` from the take cycle.
- R8: `redirect_cause` gives the lowest index among the pending, enabled bits at the take.
- R9: After a take, no further redirect occurs until `svc_done` has been seen at an edge. The earliest next pulse comes two edges after that edge.
- R10: `wake` is 1 whenever pending AND mask is nonzero, including while a service is open.
- R11: Pending bits for lines at index NUM_SRC through 6 do not exist and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (0 when not selected) |
| src_line | input | NUM_SRC | Hardware request lines, rising-edge sensitive |
| swi_req | input | 1 | Software interrupt strobe from the core |
| next_pc | input | PC_W | Address of the core's next instruction |
| svc_done | input | 1 | Core reports the end of interrupt service |
| redirect_valid | output | 1 | One-cycle jump request to the handler |
| redirect_addr | output | PC_W | Handler address captured at the take |
| redirect_cause | output | 3 | Index of the flag that was taken |
| wake | output | 1 | Releases a halted core |

## Verification
Two pairs of events can fall on the same edge. The first pair is a software write that clears the pending byte and a new source edge. The bench issues both from the same falling edge, then reads the byte back and expects the new flag kept and every other bit cleared. The second pair is the end-of-service strobe and a flag that is still pending. The bench keeps an enabled flag pending while a service is open, checks that no pulse appears while the service is open, then drives `svc_done`. It expects the next pulse exactly two edges later, with the correct cause and a freshly captured return address.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int FLAG_W  = 8;
   localparam int SWI_BIT = 7;

   localparam logic [2:0] OFS_RET_LO = 3'd0;
   localparam logic [2:0] OFS_RET_HI = 3'd1;
   localparam logic [2:0] OFS_MASK   = 3'd2;
   localparam logic [2:0] OFS_STATE  = 3'd3;
   localparam logic [2:0] OFS_HND_LO = 3'd4;
   localparam logic [2:0] OFS_HND_HI = 3'd5;

   // bits that physically exist in the pending byte
   function automatic logic [FLAG_W-1:0] impl_bits(input int n_src);
      logic [FLAG_W-1:0] r;
      for (int i = 0; i < FLAG_W; i++)
         r[i] = (i < n_src) || (i == SWI_BIT);
      return r;
   endfunction

   // lowest set bit index wins
   function automatic logic [2:0] lowest_index(input logic [FLAG_W-1:0] v);
      logic [2:0] r;
      r = 3'd0;
      for (int i = FLAG_W - 1; i >= 0; i--)
         if (v[i]) r = 3'(i);
      return r;
   endfunction
endpackage

// File: rtl/irq_edge.sv
module irq_edge #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines,
   output logic [N-1:0] rise
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lines[i];
      end
      assign rise[i] = lines[i] & ~prev_q;
   end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
   import irq_ctrl_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int PC_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [7:0]        wr_data,
   input  logic [FLAG_W-1:0] set_vec,
   input  logic              take,
   input  logic [PC_W-1:0]   next_pc,
   output logic [FLAG_W-1:0] mask,
   output logic [FLAG_W-1:0] state,
   output logic [PC_W-1:0]   handler,
   output logic [7:0]        rd_data
);
   localparam logic [FLAG_W-1:0] IMPL = impl_bits(NUM_SRC);
   localparam int HI_W = PC_W - 8;

   logic [FLAG_W-1:0] mask_q, state_q, state_base, state_nxt;
   logic [PC_W-1:0]   hnd_q, ret_q;
   logic [15:0]       hnd16, ret16;

   always_comb begin
      state_base = (wr_en && addr == OFS_STATE) ? wr_data : state_q;
      state_nxt  = (state_base | set_vec) & IMPL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         state_q <= '0;
         hnd_q   <= '0;
         ret_q   <= '0;
      end else begin
         state_q <= state_nxt;
         if (wr_en && addr == OFS_MASK)   mask_q       <= wr_data;
         if (wr_en && addr == OFS_HND_LO) hnd_q[7:0]   <= wr_data;
         if (wr_en && addr == OFS_HND_HI) hnd_q[PC_W-1:8] <= wr_data[HI_W-1:0];
         if (take)                        ret_q        <= next_pc;
      end
   end

   assign hnd16 = 16'(hnd_q);
   assign ret16 = 16'(ret_q);

   always_comb begin
      unique case (addr)
         OFS_RET_LO: rd_data = ret16[7:0];
         OFS_RET_HI: rd_data = ret16[15:8];
         OFS_MASK:   rd_data = mask_q;
         OFS_STATE:  rd_data = state_q;
         OFS_HND_LO: rd_data = hnd16[7:0];
         OFS_HND_HI: rd_data = hnd16[15:8];
         default:    rd_data = 8'h00;
      endcase
   end

   assign mask    = mask_q;
   assign state   = state_q;
   assign handler = hnd_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec & IMPL) != '0 |=> (state_q & $past(set_vec & IMPL)) == $past(set_vec & IMPL)); // R6
   AST_RET_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(ret_q)); // R3
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_ctrl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] pend,
   input  logic              svc_done,
   output logic              take,
   output logic              redirect_valid,
   output logic [2:0]        cause
);
   logic       busy_q, valid_q;
   logic [2:0] cause_q;

   assign take = (|pend) & ~busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         valid_q <= 1'b0;
         cause_q <= '0;
      end else begin
         valid_q <= take;
         if (take) begin
            busy_q  <= 1'b1;
            cause_q <= lowest_index(pend);
         end else if (svc_done) begin
            busy_q  <= 1'b0;
         end
      end
   end

   assign redirect_valid = valid_q;
   assign cause          = cause_q;

   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q); // R7
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !svc_done) |=> !valid_q); // R9
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int PC_W    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [2:0]         bus_addr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   input  logic [NUM_SRC-1:0] src_line,
   input  logic               swi_req,
   input  logic [PC_W-1:0]    next_pc,
   input  logic               svc_done,
   output logic               redirect_valid,
   output logic [PC_W-1:0]    redirect_addr,
   output logic [2:0]         redirect_cause,
   output logic               wake
);
   if (NUM_SRC < 1 || NUM_SRC > SWI_BIT) begin : g_bad_src
      $error("NUM_SRC must lie in 1..7");
   end
   if (PC_W < 9 || PC_W > 16) begin : g_bad_pc
      $error("PC_W must lie in 9..16");
   end

   logic [NUM_SRC-1:0] rise;
   logic [FLAG_W-1:0]  set_vec, mask, state, pend;
   logic [PC_W-1:0]    handler, raddr_q;
   logic [7:0]         rd_data;
   logic               take;

   irq_edge #(.N(NUM_SRC)) u_edge (
      .clk(clk), .rst_n(rst_n), .lines(src_line), .rise(rise));

   always_comb begin
      set_vec = '0;
      set_vec[NUM_SRC-1:0] = rise;
      set_vec[SWI_BIT]     = swi_req;
   end

   irq_regs #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_sel & bus_we), .addr(bus_addr),
      .wr_data(bus_wdata), .set_vec(set_vec), .take(take), .next_pc(next_pc),
      .mask(mask), .state(state), .handler(handler), .rd_data(rd_data));

   assign pend = state & mask;
   assign wake = |pend;

   irq_arbiter u_arb (
      .clk(clk), .rst_n(rst_n), .pend(pend), .svc_done(svc_done),
      .take(take), .redirect_valid(redirect_valid), .cause(redirect_cause));

   always_ff @(posedge clk) begin
      if (!rst_n)    raddr_q <= '0;
      else if (take) raddr_q <= handler;
   end

   assign redirect_addr = raddr_q;
   assign bus_rdata     = (bus_sel && !bus_we) ? rd_data : 8'h00;
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
   localparam int NS = 4;
   logic clk = 0, rst_n = 0;
   logic bus_sel = 0, bus_we = 0;
   logic [2:0] bus_addr = 0;
   logic [7:0] bus_wdata = 0, bus_rdata;
   logic [NS-1:0] src_line = 0;
   logic swi_req = 0, svc_done = 0;
   logic [15:0] next_pc = 0, redirect_addr;
   logic redirect_valid, wake;
   logic [2:0] redirect_cause;
   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_ctrl #(.NUM_SRC(NS), .PC_W(16)) i_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_line(src_line), .swi_req(swi_req), .next_pc(next_pc),
      .svc_done(svc_done), .redirect_valid(redirect_valid),
      .redirect_addr(redirect_addr), .redirect_cause(redirect_cause), .wake(wake));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic finish_svc();
      wr(3'd3, 8'h00);
      svc_done = 1;
      @(negedge clk);
      svc_done = 0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), d);
         chk("R1 reset register", d, 0);
      end
      chk("R1 reset redirect_valid", redirect_valid, 0);
      chk("R1 reset wake", wake, 0);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr(3'd4, 8'h34);
      wr(3'd5, 8'h12);
      rd(3'd4, d); chk("R2 R3 handler low byte", d, 8'h34);
      rd(3'd5, d); chk("R2 R3 handler high byte", d, 8'h12);
      wr(3'd2, 8'hA0);
      rd(3'd2, d); chk("R3 mask readback", d, 8'hA0);
      wr(3'd2, 8'h00);
      wr(3'd0, 8'hAA);
      wr(3'd1, 8'h55);
      rd(3'd0, d); chk("R3 return low read-only", d, 0);
      rd(3'd1, d); chk("R3 return high read-only", d, 0);
      rd(3'd6, d); chk("R2 offset 6 reads zero", d, 0);
      rd(3'd7, d); chk("R2 offset 7 reads zero", d, 0);
   endtask

   task automatic t_edge();
      logic [7:0] d;
      @(negedge clk); src_line[1] = 1;
      @(negedge clk);
      rd(3'd3, d); chk("R4 rising edge sets bit 1", d, 8'h02);
      chk("R10 masked flag no wake", wake, 0);
      wr(3'd3, 8'h00);
      repeat (3) @(negedge clk);
      rd(3'd3, d); chk("R4 held level does not re-set", d, 8'h00);
      src_line[1] = 0;
      @(negedge clk);
   endtask

   task automatic t_unimpl();
      logic [7:0] d;
      wr(3'd3, 8'hFF);
      rd(3'd3, d); chk("R11 R6 only implemented bits stored", d, 8'h8F);
      wr(3'd3, 8'h00);
      rd(3'd3, d); chk("R6 write zero clears", d, 8'h00);
   endtask

   task automatic t_swi();
      logic [7:0] d;
      @(negedge clk); swi_req = 1;
      @(negedge clk); swi_req = 0;
      rd(3'd3, d); chk("R5 software strobe sets bit 7", d, 8'h80);
      wr(3'd3, 8'h00);
   endtask

   task automatic t_take();
      logic [7:0] d;
      wr(3'd2, 8'h04);
      next_pc = 16'hBEEF;
      @(negedge clk); src_line[2] = 1;
      @(negedge clk);
      chk("R10 wake on enabled pending", wake, 1);
      chk("R7 no pulse before take edge", redirect_valid, 0);
      @(negedge clk);
      chk("R7 pulse", redirect_valid, 1);
      chk("R7 handler address", redirect_addr, 16'h1234);
      chk("R8 cause 2", redirect_cause, 2);
      rd(3'd0, d); chk("R7 return low", d, 8'hEF);
      rd(3'd1, d); chk("R7 return high", d, 8'hBE);
      @(negedge clk);
      chk("R7 pulse lasts one cycle", redirect_valid, 0);
      chk("R10 wake while servicing", wake, 1);
      src_line[2] = 0;
      finish_svc();
   endtask

   task automatic t_priority();
      logic [7:0] d;
      bit seen;
      wr(3'd2, 8'h0A);
      next_pc = 16'h0042;
      @(negedge clk); src_line[1] = 1; src_line[3] = 1;
      @(negedge clk);
      @(negedge clk);
      chk("R8 pulse for two sources", redirect_valid, 1);
      chk("R8 lowest index wins", redirect_cause, 1);
      wr(3'd3, 8'h08);
      next_pc = 16'h0100;
      seen = 0;
      repeat (4) begin
         @(negedge clk);
         if (redirect_valid) seen = 1;
      end
      chk("R9 no retake while servicing", seen, 0);
      svc_done = 1;
      @(negedge clk); svc_done = 0;
      chk("R9 no pulse one edge after done", redirect_valid, 0);
      @(negedge clk);
      chk("R9 pulse two edges after done", redirect_valid, 1);
      chk("R8 remaining cause 3", redirect_cause, 3);
      rd(3'd0, d); chk("R7 return recaptured", d, 8'h00);
      rd(3'd1, d); chk("R7 return recaptured high", d, 8'h01);
      src_line = 0;
      finish_svc();
   endtask

   task automatic t_collide();
      logic [7:0] d;
      wr(3'd2, 8'h00);
      @(negedge clk); swi_req = 1;
      @(negedge clk); swi_req = 0;
      bus_sel = 1; bus_we = 1; bus_addr = 3'd3; bus_wdata = 8'h00;
      src_line[0] = 1;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
      rd(3'd3, d); chk("R6 new edge wins over clearing write", d, 8'h01);
      wr(3'd2, 8'h01);
      chk("R10 wake after unmasking", wake, 1);
      src_line[0] = 0;
      finish_svc();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_edge();
      t_unimpl();
      t_swi();
      t_take();
      t_priority();
      t_collide();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule